// File: doc/BRIEF.md
# Dual-Timer Pixel Hit Coincidence

This block is the digital back end of a single detector pixel. Each rising edge of the discriminator output starts a delay timer. The timer waits a programmable number of clock cycles, the trigger latency. It then opens a coincidence window two cycles wide. If the global trigger is seen inside that window, the timer sets a latched flag, which a scanning readout later samples and clears. A hit whose window closes without a trigger is discarded as background.

The pixel carries two independent timers. A second hit that arrives while the first timer is still counting therefore starts the other timer and is not lost. New hits always go to the lowest-indexed idle timer. A hit that finds every timer busy is dropped, and a sticky overflow flag records the loss. One readout-clear strobe clears all flags at once. The clock is nominally 16 MHz, so each cycle lasts 62.5 ns.

Top module: `pxc_dual_timer`

## Requirements
- R1: While rst_ni is low, every timer is idle and flag_o, any_hit_o and overflow_o are 0. A timer that was running when reset arrived produces no flag afterwards.
- R2: Only a rising edge of hit_i starts a timer, with hit_i low at the previous clock edge and high at the current one. A level held high for many cycles starts exactly one timer.
- R3: A new hit goes to the lowest-indexed idle timer. A hit that arrives while timer 0 is busy starts timer 1, and its result appears on bit 1 of flag_o.
- R4: lat_i is sampled at the edge where a timer starts. Changing it afterwards does not affect that timer. A sampled value of 0 acts as a latency of 1.
- R5: Let n be the edge at which a hit starts a timer, and let L be its latency. The timer sets its flag if trig_i is high at edge n+L or at edge n+L+1. A trigger at any other edge sets nothing.
- R6: A flag becomes visible in the cycle after the edge that sets it. It then stays high until clr_i.
- R7: When clr_i is high at an edge, every flag is 0 after that edge. This holds even if a coincidence would have set a flag at the same edge.
- R8: A hit edge that finds all timers busy is ignored and sets overflow_o. overflow_o stays set until an edge with clr_i high clears it.
- R9: any_hit_o is high exactly when at least one bit of flag_o is high.
- R10: A timer is busy from the edge after its start through edge n+L+1. It can take a new hit from edge n+L+2 onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | Discriminator output level |
| trig_i | input | 1 | Global trigger |
| lat_i | input | CNT_W | Trigger latency in cycles (0 acts as 1) |
| clr_i | input | 1 | Readout clear of flags and overflow |
| flag_o | output | N_TMR | Latched coincidence flag, one per timer |
| any_hit_o | output | 1 | OR of all flags |
| overflow_o | output | 1 | Sticky: a hit was lost because all timers were busy |

## Verification
The assertions assume that every input changes only between clock edges. They also assume that hit_i, trig_i and clr_i are defined from the first edge after reset onward. The bench meets both assumptions: it drives every input at the falling edge and holds all of them at 0 during reset. The bench starts each scenario from idle timers and cleared flags. It does this by leaving more than L+2 quiet cycles before each clear strobe, so that no timer left over from an earlier scenario can fire inside a later window.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_COUNT = 2'd1,
    TMR_WIN   = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/pxc_edge.sv
module pxc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/pxc_steer.sv
module pxc_steer #(
  parameter int unsigned N_TMR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [N_TMR-1:0] idle_i,
  output logic [N_TMR-1:0] grant_o,
  output logic             full_o
);
  always_comb begin
    logic taken;
    taken   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (req_i && idle_i[i] && !taken) begin
        grant_o[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

  assign full_o = req_i & ~(|idle_i);

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R3
  AST_GRANT_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && |idle_i) |-> $countones(grant_o) == 1); // R3
endmodule

// File: rtl/pxc_timer.sv
module pxc_timer
  import pxc_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] lat_i,
  input  logic             trig_i,
  input  logic             clr_i,
  output logic             idle_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] LAT_MIN = CNT_W'(1);

  tmr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lat_eff;
  logic             in_win;
  logic             flag_q;

  assign lat_eff = (lat_i == '0) ? LAT_MIN : lat_i;
  // window spans edge n+L (count reaches 0) and edge n+L+1
  assign in_win  = ((state_q == TMR_COUNT) && (cnt_q == '0)) || (state_q == TMR_WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        TMR_IDLE: if (start_i) begin
          state_q <= TMR_COUNT;
          cnt_q   <= lat_eff - LAT_MIN;
        end
        TMR_COUNT: begin
          if (cnt_q == '0) state_q <= TMR_WIN;
          else             cnt_q   <= cnt_q - LAT_MIN;
        end
        TMR_WIN:  state_q <= TMR_IDLE;
        default:  state_q <= TMR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (clr_i)             flag_q <= 1'b0;
    else if (in_win && trig_i)  flag_q <= 1'b1;
  end

  assign idle_o = (state_q == TMR_IDLE);
  assign flag_o = flag_q;

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> state_q == TMR_IDLE); // R10
  AST_WIN_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == TMR_WIN |=> state_q == TMR_IDLE); // R5
  AST_SET_NEEDS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(trig_i) && !$past(clr_i)); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q); // R6
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_q); // R7
endmodule

// File: rtl/pxc_dual_timer.sv
module pxc_dual_timer #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned N_TMR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] lat_i,
  input  logic             clr_i,
  output logic [N_TMR-1:0] flag_o,
  output logic             any_hit_o,
  output logic             overflow_o
);
  logic             hit_rise;
  logic             all_busy;
  logic [N_TMR-1:0] idle;
  logic [N_TMR-1:0] grant;
  logic             ovf_q;

  pxc_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (hit_i),
    .rise_o (hit_rise)
  );

  pxc_steer #(.N_TMR(N_TMR)) u_steer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (hit_rise),
    .idle_i  (idle),
    .grant_o (grant),
    .full_o  (all_busy)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    pxc_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (grant[g]),
      .lat_i   (lat_i),
      .trig_i  (trig_i),
      .clr_i   (clr_i),
      .idle_o  (idle[g]),
      .flag_o  (flag_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovf_q <= 1'b0;
    else if (clr_i)    ovf_q <= 1'b0;
    else if (all_busy) ovf_q <= 1'b1;
  end

  assign overflow_o = ovf_q;
  assign any_hit_o  = |flag_o;

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !clr_i |=> overflow_o); // R8
  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !overflow_o); // R8
  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(hit_rise) && $past(idle) == '0); // R8
endmodule

// File: tb/sim_pxc_dual_timer.sv
module sim_pxc_dual_timer;
  localparam int CLK_PERIOD = 20;
  localparam int CNT_W = 7;
  localparam int N_TMR = 2;
  localparam int MAXC  = 160;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             hit_i = 1'b0;
  logic             trig_i = 1'b0;
  logic [CNT_W-1:0] lat_i = '0;
  logic             clr_i = 1'b0;
  logic [N_TMR-1:0] flag_o;
  logic             any_hit_o;
  logic             overflow_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxc_dual_timer #(.CNT_W(CNT_W), .N_TMR(N_TMR)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hit_i(hit_i), .trig_i(trig_i),
    .lat_i(lat_i), .clr_i(clr_i), .flag_o(flag_o),
    .any_hit_o(any_hit_o), .overflow_o(overflow_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
  endtask

  // bit k of each mask is the value seen at edge k; edge 0 is the first driven edge
  task automatic drive(input int ncyc, input logic [MAXC-1:0] hm,
                       input logic [MAXC-1:0] tm, input logic [MAXC-1:0] cm,
                       input int lat_a, input int lat_b);
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      hit_i  = hm[k];
      trig_i = tm[k];
      clr_i  = cm[k];
      lat_i  = CNT_W'((k == 0) ? lat_a : lat_b);
    end
    @(negedge clk);
    hit_i = 1'b0; trig_i = 1'b0; clr_i = 1'b0;
  endtask

  function automatic logic [MAXC-1:0] bit_at(input int k);
    logic [MAXC-1:0] v;
    v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  task automatic t_window(input int lat, input int d, input int exp);
    clear_all();
    drive(lat + 4, bit_at(0), bit_at(d), '0, lat, lat);
    check($sformatf("R5 lat=%0d trig at +%0d", lat, d), flag_o, exp);
    check("R9 any_hit", any_hit_o, (exp != 0) ? 1 : 0);
  endtask

  task automatic t_lat_zero();
    clear_all();
    drive(6, bit_at(0), bit_at(1), '0, 0, 0);
    check("R4 lat 0 acts as 1, trig +1", flag_o, 1);
    clear_all();
    drive(6, bit_at(0), bit_at(3), '0, 0, 0);
    check("R4 lat 0, trig +3", flag_o, 0);
  endtask

  task automatic t_lat_sampled();
    clear_all();
    drive(30, bit_at(0), bit_at(5), '0, 5, 20);
    check("R4 lat change after start ignored", flag_o, 1);
  endtask

  task automatic t_dual();
    clear_all();
    drive(20, bit_at(0) | bit_at(3), bit_at(14), '0, 10, 10);
    check("R3 second hit on timer 1", flag_o, 2);
    clear_all();
    drive(20, bit_at(0) | bit_at(3), bit_at(10), '0, 10, 10);
    check("R3 first hit on timer 0", flag_o, 1);
    check("R8 no overflow with two hits", overflow_o, 0);
  endtask

  task automatic t_level();
    clear_all();
    drive(12, bit_at(0) | bit_at(1) | bit_at(2) | bit_at(3) | bit_at(4),
          bit_at(4) | bit_at(7), '0, 4, 4);
    check("R2 held level starts one timer", flag_o, 1);
    check("R2 held level no overflow", overflow_o, 0);
  endtask

  task automatic t_overflow();
    clear_all();
    drive(30, bit_at(0) | bit_at(2) | bit_at(4), bit_at(24), '0, 20, 20);
    check("R8 third hit dropped", flag_o, 0);
    check("R8 overflow set", overflow_o, 1);
    repeat (5) @(negedge clk);
    check("R8 overflow sticky", overflow_o, 1);
    clear_all();
    check("R8 overflow cleared", overflow_o, 0);
  endtask

  task automatic t_clear();
    clear_all();
    drive(10, bit_at(0), bit_at(6), bit_at(6), 6, 6);
    check("R7 clear beats set", flag_o, 0);
    clear_all();
    drive(10, bit_at(0), bit_at(6), '0, 6, 6);
    repeat (12) @(negedge clk);
    check("R6 flag held", flag_o, 1);
    check("R9 any_hit held", any_hit_o, 1);
    clear_all();
    check("R7 clear", flag_o, 0);
    check("R9 any_hit low", any_hit_o, 0);
  endtask

  task automatic t_reuse();
    clear_all();
    drive(12, bit_at(0) | bit_at(5), bit_at(8), '0, 3, 3);
    check("R10 timer 0 free at n+L+2", flag_o, 1);
    clear_all();
    drive(12, bit_at(0) | bit_at(4), bit_at(7), '0, 3, 3);
    check("R10 timer 0 busy at n+L+1", flag_o, 2);
  endtask

  task automatic t_max_lat();
    clear_all();
    drive(MAXC - 20, bit_at(0), bit_at(128), '0, 127, 127);
    check("R5 max latency 127, trig +128", flag_o, 1);
  endtask

  task automatic t_reset_mid();
    clear_all();
    fork
      drive(12, bit_at(0), bit_at(5), '0, 5, 5);
      begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_ni = 1'b0;
        check("R1 flags in reset", flag_o, 0);
        @(negedge clk);
        rst_ni = 1'b1;
      end
    join
    check("R1 aborted timer gives no flag", flag_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", flag_o, 0);
    check("R1 any_hit in reset", any_hit_o, 0);
    check("R1 overflow in reset", overflow_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_window(8, 7, 0);
    t_window(8, 8, 1);
    t_window(8, 9, 1);
    t_window(8, 10, 0);
    t_window(1, 2, 1);
    t_lat_zero();
    t_lat_sampled();
    t_dual();
    t_level();
    t_overflow();
    t_clear();
    t_reuse();
    t_max_lat();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule